// File: doc/BRIEF.md
# Shared Work Memory Ownership Register

This block is the control register shared by two processors, a host side and a worker side, that decides who may use a shared work memory. The memory runs either as one large bank that belongs to a single side at a time (whole mode), or as two half banks that are swapped between the sides (split mode). The host side requests the memory for the worker by setting a request flag and also writes bank and write-protect fields. The worker side picks the mode and hands the memory back with a return flag.

The block drives an owner select for the memory multiplexer and a halt flag for the graphics sequencer. The sequencer must stop while the whole memory belongs to the host. Whenever ownership changes while a graphics operation is busy, the block sends a one-cycle resync pulse so that the sequencer can realign its own timing.

Top module: `wmem_own_ctrl`

## Requirements
- R1: After reset, `ctl_view` reads 16'h0001: whole mode, return flag set, request flag clear, bank and protect fields zero. `own_sub` is 0 and `gfx_halt` is 1.
- R2: The `ctl_view` layout is {protect[7:0] at 15:8, bank[1:0] at 7:6, zeros at 5:3, mode at 2 (1 = split), request at 1, return at 0}.
- R3: In whole mode, a host write with data bit 1 set makes request=1 and return=0 in the next cycle, and the bank field takes data bits 7:6.
- R4: In whole mode, a host write with data bit 1 clear leaves request and return unchanged and updates only the bank field, plus the protect field for word writes.
- R5: In split mode, every host write makes request=1 in the next cycle, whatever data bit 1 holds.
- R6: A host word write (`host_word`=1) loads protect from data bits 15:8. A host byte write leaves protect unchanged.
- R7: A worker write sets mode from data bit 2. If the new mode is whole and data bit 0 is 1, then return=1 and request=0. If the new mode is whole and data bit 0 is 0, both flags are kept. If the new mode is split, return takes data bit 0 and request is kept.
- R8: When host and worker write in the same cycle, the worker's effect on request and return wins. The host's bank and protect updates still apply.
- R9: `own_sub` is the inverse of the return flag.
- R10: `gfx_halt` is 1 exactly when mode is whole and return is 1.
- R11: `gfx_resync` is high for one cycle, in the cycle after a clock edge where the return flag changed while `gfx_busy` was 1. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host-side write strobe |
| host_word | input | 1 | 1 = word write (protect reached), 0 = low byte only |
| host_wdata | input | 16 | Host-side write data |
| sub_wr | input | 1 | Worker-side write strobe |
| sub_wdata | input | 8 | Worker-side write data |
| gfx_busy | input | 1 | Graphics operation in progress |
| ctl_view | output | 16 | Register contents |
| own_sub | output | 1 | 1 = worker side owns the memory or bank |
| gfx_halt | output | 1 | Graphics sequencer must stall |
| gfx_resync | output | 1 | One-cycle resync request |

## Verification
All register fields, and so `ctl_view`, `own_sub` and `gfx_halt`, change at the first clock edge after a write strobe. `gfx_resync` is registered at that same edge, so it is also due one cycle after the stimulus. The bench drives inputs and samples outputs on the falling edge. Before driving each new stimulus it compares every output against a bench model, and it advances the model by exactly one step per rising edge, so each result is checked in the cycle it is due. Random traffic in both modes, including simultaneous writes, is combined with directed cases for the written-zero rules.

// File: rtl/wmem_own_pkg.sv
package wmem_own_pkg;
  parameter int PROT_W = 8;
  parameter int BANK_W = 2;
  localparam int VIEW_W = PROT_W + BANK_W + 6;

  typedef struct packed {
    logic [PROT_W-1:0] prot;
    logic [BANK_W-1:0] bank;
    logic              split;
    logic              req;
    logic              ret;
  } own_state_t;

  localparam own_state_t OWN_RESET = '{prot: '0, bank: '0, split: 1'b0, req: 1'b0, ret: 1'b1};

  function automatic logic [VIEW_W-1:0] pack_view(own_state_t s);
    return {s.prot, s.bank, 3'b000, s.split, s.req, s.ret};
  endfunction

  function automatic logic halt_of(own_state_t s);
    return !s.split && s.ret;
  endfunction
endpackage

// File: rtl/wmem_host_port.sv
module wmem_host_port
  import wmem_own_pkg::*;
(
  input  own_state_t              cur,
  input  logic                    wr,
  input  logic                    word,
  input  logic [VIEW_W-1:0]       wdata,
  output own_state_t              nxt,
  output logic                    grant_ev
);
  localparam int BANK_LO = 6;

  always_comb begin
    nxt      = cur;
    grant_ev = 1'b0;
    if (wr) begin
      nxt.bank = wdata[BANK_LO +: BANK_W];
      if (word) nxt.prot = wdata[VIEW_W-1 -: PROT_W];
      if (cur.split) begin
        nxt.req = 1'b1;
      end else if (wdata[1]) begin
        nxt.req  = 1'b1;
        nxt.ret  = 1'b0;
        grant_ev = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wmem_sub_port.sv
module wmem_sub_port
  import wmem_own_pkg::*;
(
  input  own_state_t  cur,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output own_state_t  nxt,
  output logic        return_ev
);
  always_comb begin
    nxt       = cur;
    return_ev = 1'b0;
    if (wr) begin
      nxt.split = wdata[2];
      if (wdata[2]) begin
        nxt.ret = wdata[0];
      end else if (wdata[0]) begin
        nxt.ret   = 1'b1;
        nxt.req   = 1'b0;
        return_ev = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wmem_resync.sv
module wmem_resync (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_now,
  input  logic ret_next,
  input  logic busy,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= (ret_now != ret_next) && busy;
  end
endmodule

// File: rtl/wmem_own_ctrl.sv
module wmem_own_ctrl
  import wmem_own_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [15:0]       host_wdata,
  input  logic              sub_wr,
  input  logic [7:0]        sub_wdata,
  input  logic              gfx_busy,
  output logic [15:0]       ctl_view,
  output logic              own_sub,
  output logic              gfx_halt,
  output logic              gfx_resync
);
  own_state_t st_q, st_h, st_d;
  logic host_grant_ev, sub_return_ev;

  wmem_host_port u_host (
    .cur(st_q), .wr(host_wr), .word(host_word), .wdata(host_wdata),
    .nxt(st_h), .grant_ev(host_grant_ev)
  );

  wmem_sub_port u_sub (
    .cur(st_h), .wr(sub_wr), .wdata(sub_wdata),
    .nxt(st_d), .return_ev(sub_return_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= OWN_RESET;
    else        st_q <= st_d;
  end

  wmem_resync u_rs (
    .clk(clk), .rst_n(rst_n), .ret_now(st_q.ret), .ret_next(st_d.ret),
    .busy(gfx_busy), .pulse(gfx_resync)
  );

  assign ctl_view = pack_view(st_q);
  assign own_sub  = ~st_q.ret;
  assign gfx_halt = halt_of(st_q);
endmodule

// File: rtl/wmem_own_chk.sv
module wmem_own_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_word,
  input logic [15:0] host_wdata,
  input logic        sub_wr,
  input logic [7:0]  sub_wdata,
  input logic        gfx_busy,
  input logic [15:0] ctl_view,
  input logic        own_sub,
  input logic        gfx_halt,
  input logic        gfx_resync,
  input logic        host_grant_ev,
  input logic        sub_return_ev
);
  a_r3_grant_clears_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ctl_view[2] && host_wdata[1] && !sub_wr) |=> (ctl_view[1] && !ctl_view[0] && !gfx_halt));

  a_r4_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ctl_view[2] && !host_wdata[1] && !sub_wr) |=> ($stable(ctl_view[1:0]) && $stable(own_sub)));

  a_r5_split_forces_req: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && ctl_view[2] && !sub_wr) |=> ctl_view[1]);

  a_r6_byte_keeps_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_wr && host_word)) |=> $stable(ctl_view[15:8]));

  a_r7_return_event: assert property (@(posedge clk) disable iff (!rst_n)
    sub_return_ev |=> (ctl_view[0] && !ctl_view[1] && gfx_halt));

  a_r8_sub_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant_ev && sub_return_ev) |=> !own_sub);

  a_r11_resync_cause: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_resync |-> ($past(gfx_busy) && (own_sub != $past(own_sub))));

  a_r11_resync_due: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_busy && host_grant_ev && !sub_wr && !own_sub) |=> gfx_resync);
endmodule

bind wmem_own_ctrl wmem_own_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_word(host_word),
  .host_wdata(host_wdata), .sub_wr(sub_wr), .sub_wdata(sub_wdata),
  .gfx_busy(gfx_busy), .ctl_view(ctl_view), .own_sub(own_sub),
  .gfx_halt(gfx_halt), .gfx_resync(gfx_resync),
  .host_grant_ev(host_grant_ev), .sub_return_ev(sub_return_ev)
);

// File: tb/sim_wmem_own_ctrl.sv
module sim_wmem_own_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_word = 1'b0, sub_wr = 1'b0, gfx_busy = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  sub_wdata = '0;
  logic [15:0] ctl_view;
  logic own_sub, gfx_halt, gfx_resync;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;

  // Bench model fields
  logic [7:0] m_prot;
  logic [1:0] m_bank;
  logic m_split, m_req, m_ret, m_pulse;

  always #2 clk = ~clk;

  wmem_own_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_word(host_word),
    .host_wdata(host_wdata), .sub_wr(sub_wr), .sub_wdata(sub_wdata),
    .gfx_busy(gfx_busy), .ctl_view(ctl_view), .own_sub(own_sub),
    .gfx_halt(gfx_halt), .gfx_resync(gfx_resync)
  );

  function automatic logic [15:0] exp_view();
    logic [15:0] v;
    v = 16'h0000;
    v[15:8] = m_prot;
    v[7:6]  = m_bank;
    v[2]    = m_split;
    v[1]    = m_req;
    v[0]    = m_ret;
    return v;
  endfunction

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R2 view"}, ctl_view, exp_view());
    cmp({tag, " R9 own_sub"}, {15'd0, own_sub}, {15'd0, ~m_ret});
    cmp({tag, " R10 halt"}, {15'd0, gfx_halt}, {15'd0, (!m_split && m_ret)});
    cmp({tag, " R11 resync"}, {15'd0, gfx_resync}, {15'd0, m_pulse});
  endtask

  // Advance the model by one rising edge using the currently driven inputs
  task automatic model_step();
    logic old_ret;
    old_ret = m_ret;
    if (host_wr) begin
      m_bank = host_wdata[7:6];
      if (host_word) m_prot = host_wdata[15:8];
      if (m_split) m_req = 1'b1;             // R5
      else if (host_wdata[1]) begin          // R3
        m_req = 1'b1;
        m_ret = 1'b0;
      end                                    // R4: otherwise flags kept
    end
    if (sub_wr) begin                        // R7, applied last for R8
      m_split = sub_wdata[2];
      if (sub_wdata[2]) m_ret = sub_wdata[0];
      else if (sub_wdata[0]) begin
        m_ret = 1'b1;
        m_req = 1'b0;
      end
    end
    m_pulse = (old_ret != m_ret) && gfx_busy; // R11
  endtask

  task automatic cycle(input logic hw, input logic hword, input logic [15:0] hd,
                       input logic sw, input logic [7:0] sd, input logic busy,
                       input string tag);
    @(negedge clk);
    cyc++;
    check_all(tag);
    host_wr = hw; host_word = hword; host_wdata = hd;
    sub_wr = sw; sub_wdata = sd; gfx_busy = busy;
    model_step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd1234);
    m_prot = 8'h00; m_bank = 2'b00; m_split = 1'b0; m_req = 1'b0; m_ret = 1'b1; m_pulse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cmp("R1 reset view", ctl_view, 16'h0001);
    cmp("R1 reset own", {15'd0, own_sub}, 16'd0);
    cmp("R1 reset halt", {15'd0, gfx_halt}, 16'd1);
    // Directed: R4 write zero in whole mode ignored, byte write (R6)
    cycle(1, 0, 16'hFFC0, 0, 8'h00, 1, "R4 zero-in-whole");
    // R3 grant while busy -> resync
    cycle(1, 1, 16'hA542, 0, 8'h00, 1, "R3 grant");
    cycle(0, 0, 16'h0000, 0, 8'h00, 0, "R3 R11 after grant");
    // R7 return in whole mode
    cycle(0, 0, 16'h0000, 1, 8'h01, 1, "R7 return");
    cycle(0, 0, 16'h0000, 0, 8'h00, 0, "R7 R11 after return");
    // R8 simultaneous grant and return
    cycle(1, 0, 16'h0002, 1, 8'h01, 1, "R8 simultaneous");
    cycle(0, 0, 16'h0000, 0, 8'h00, 0, "R8 after");
    // R5 split mode then host write zero still sets request
    cycle(0, 0, 16'h0000, 1, 8'h04, 0, "R7 to split");
    cycle(1, 0, 16'h0000, 0, 8'h00, 0, "R5 zero-in-split");
    cycle(0, 0, 16'h0000, 0, 8'h00, 0, "R5 after");
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] & r[1], r[2], r[31:16], r[3] & r[4] & r[5], {r[15:8] & 8'h07}, r[6], "random");
    end
    cycle(0, 0, 16'h0000, 0, 8'h00, 0, "final");
    @(negedge clk);
    cyc++;
    check_all("final");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule